// File: doc/BRIEF.md
# Radix-4 Booth Fractional Multiplier

This block multiplies two signed fixed-point fractions of W bits each. In each operand the most significant bit has weight -1 and the remaining bits have weights 2^-1 down to 2^-(W-1). The multiplier operand is split into overlapping three-bit groups. Each group selects one signed digit from the set {-2, -1, 0, +1, +2}. Each digit in turn picks a partial product: zero, the multiplicand, twice the multiplicand, or the negation of either. The block adds one partial product per clock into a sign-extended accumulator, so a W-bit multiply takes ceil(W/2) cycles, which is half the count of a plain shift-and-add design.

The block returns the result at the input word length. It keeps the W most significant bits of the 2W-1 significant product bits and drops the rest by truncation, which rounds toward minus infinity. The one product that cannot be represented, -1 times -1, is clamped to the largest positive fraction. A host drives both operands, pulses `startIn`, and collects `prodOut` when `validOut` pulses a fixed number of cycles later.

Top module: `boothFracMul`

## Requirements
- R1: While `rstN` is low, and after it is released until the first result, `prodOut` is all zeros and `validOut` is 0.
- R2: Read the operands and the result as W-bit two's-complement integers a, b and p. Then p equals floor(a*b / 2^(W-1)) for every operand pair except the one named in R3.
- R3: When both operands equal -2^(W-1) (bit pattern 1 followed by zeros), `prodOut` is 2^(W-1)-1 (0 followed by ones; 0x7F for W=8).
- R4: A `startIn` that is accepted on a rising edge makes `validOut` high for exactly one cycle. That cycle starts at the ceil(W/2)-th rising edge after the accepted edge.
- R5: A `startIn` that arrives while an operation is in progress is ignored. The block produces no extra result, and the current result still uses the operands captured at the accepted start. Operand inputs matter only on the edge that accepts a start.
- R6: `prodOut` keeps its value from one result until the next result, whatever happens on the operand inputs.
- R7: Odd W is supported. The multiplier is sign-extended by one bit so that the digits pair evenly, and R2 to R4 hold for W=5 with a latency of 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start strobe; accepted only while idle |
| aIn | input | W | Multiplicand fraction, two's complement |
| bIn | input | W | Multiplier fraction, two's complement |
| prodOut | output | W | Truncated product, held until the next result |
| validOut | output | 1 | One-cycle pulse marking a new `prodOut` |

## Verification
Each result is due ceil(W/2) rising edges after the edge that accepted `startIn`: 4 edges for the default W=8 and 3 edges for W=5. The bench drives stimulus on falling edges. It steps falling edge by falling edge after each start, requires `validOut` low at every step before the due one, and reads `prodOut` and `validOut` at the falling edge just after the due rising edge. For the ignored-start and hold cases, it keeps sampling for several further cycles to confirm that no second pulse appears and that `prodOut` does not move.

// File: rtl/boothPkg.sv
package boothPkg;
  // Strobes from the sequencer to the datapath, valid for the current cycle.
  typedef struct packed {
    logic load;   // capture operands and clear the accumulator
    logic step;   // fold in one recoded digit
    logic last;   // final digit: publish the result
  } ctlStrobes_t;
endpackage

// File: rtl/boothDigit.sv
// Recodes one overlapping bit triplet {x[i+1], x[i], x[i-1]} into a selection
// for the signed digit -2*x[i+1] + x[i] + x[i-1].
module boothDigit (
  input  logic [2:0] triplet,
  output logic       selOne,
  output logic       selTwo,
  output logic       selNeg
);
  always_comb begin
    selOne = 1'b0;
    selTwo = 1'b0;
    selNeg = 1'b0;
    case (triplet)
      3'b001, 3'b010: selOne = 1'b1;                   // +1
      3'b011:         selTwo = 1'b1;                   // +2
      3'b100:         begin selTwo = 1'b1; selNeg = 1'b1; end  // -2
      3'b101, 3'b110: begin selOne = 1'b1; selNeg = 1'b1; end  // -1
      default: ;                                       // 0
    endcase
  end
endmodule

// File: rtl/boothCtl.sv
module boothCtl #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startIn,
  output boothPkg::ctlStrobes_t ctl,
  output logic                  busy
);
  localparam int NDIG = (W + 1) / 2;
  localparam int CW   = $clog2(NDIG + 1);

  logic [CW-1:0] digitCnt;

  always_comb begin
    ctl.load = startIn && !busy;
    ctl.step = busy;
    ctl.last = busy && (digitCnt == CW'(NDIG - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      digitCnt <= '0;
    end else if (ctl.load) begin
      busy     <= 1'b1;
      digitCnt <= '0;
    end else if (ctl.last) begin
      busy     <= 1'b0;
      digitCnt <= '0;
    end else if (ctl.step) begin
      digitCnt <= digitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/boothDatapath.sv
module boothDatapath #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  boothPkg::ctlStrobes_t ctl,
  input  logic [W-1:0]          aIn,
  input  logic [W-1:0]          bIn,
  output logic [W-1:0]          prodOut,
  output logic                  validOut
);
  localparam int NDIG = (W + 1) / 2;        // recoded digits
  localparam int BEXT = 2 * NDIG + 1;       // multiplier plus reference bit
  localparam int PPW  = W + 2;              // +/-2*A needs two guard bits
  localparam int ACCW = 2 * NDIG + PPW + 1; // accumulator with one guard bit

  logic        [W-1:0]      aReg;
  logic        [BEXT-1:0]   mulReg;
  logic        [BEXT-1:0]   mulLoad;
  logic signed [ACCW-1:0]   acc;
  logic signed [ACCW-1:0]   ppWide;
  logic signed [ACCW-1:0]   sum;
  logic signed [ACCW-1:0]   accNext;
  logic signed [PPW-1:0]    aExt;
  logic signed [PPW-1:0]    ppMag;
  logic signed [PPW-1:0]    pp;
  logic                     selOne, selTwo, selNeg;
  logic                     overflow;
  logic        [W-1:0]      resultNext;

  // Reference bit below the LSB is 0; odd W gets one sign-extension bit.
  generate
    if (2 * NDIG == W) begin : g_even
      assign mulLoad = {bIn, 1'b0};
    end else begin : g_odd
      assign mulLoad = {bIn[W-1], bIn, 1'b0};
    end
  endgenerate

  boothDigit u_digit (
    .triplet (mulReg[2:0]),
    .selOne  (selOne),
    .selTwo  (selTwo),
    .selNeg  (selNeg)
  );

  always_comb begin
    aExt    = {{2{aReg[W-1]}}, aReg};
    ppMag   = selTwo ? (aExt <<< 1) : (selOne ? aExt : '0);
    pp      = selNeg ? -ppMag : ppMag;
    // Add at the top of the accumulator, then shift the sum right by one digit.
    ppWide  = {{(ACCW-PPW){pp[PPW-1]}}, pp} <<< (2 * NDIG);
    sum     = acc + ppWide;
    accNext = sum >>> 2;
    // After the last digit accNext is the exact 2W-bit product.
    overflow   = accNext[2*W-2] != accNext[ACCW-1];
    resultNext = overflow ? {1'b0, {(W-1){1'b1}}} : accNext[2*W-2:W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg     <= '0;
      mulReg   <= '0;
      acc      <= '0;
      prodOut  <= '0;
      validOut <= 1'b0;
    end else begin
      validOut <= 1'b0;
      if (ctl.load) begin
        aReg   <= aIn;
        mulReg <= mulLoad;
        acc    <= '0;
      end else if (ctl.step) begin
        mulReg <= mulReg >> 2;
        acc    <= accNext;
        if (ctl.last) begin
          prodOut  <= resultNext;
          validOut <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/boothFracMul.sv
module boothFracMul #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] prodOut,
  output logic         validOut
);
  boothPkg::ctlStrobes_t ctl;
  logic                  busy;

  boothCtl #(.W(W)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .ctl     (ctl),
    .busy    (busy)
  );

  boothDatapath #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .aIn      (aIn),
    .bIn      (bIn),
    .prodOut  (prodOut),
    .validOut (validOut)
  );
endmodule

// File: rtl/boothFracMul_chk.sv
module boothFracMul_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] aIn,
  input logic [W-1:0] bIn,
  input logic [W-1:0] prodOut,
  input logic         validOut,
  input logic         load,
  input logic         busy
);
  localparam int NDIG = (W + 1) / 2;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  logic [7:0] sinceLoad;
  logic       capMin;
  logic       capZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceLoad <= '0;
      capMin    <= 1'b0;
      capZero   <= 1'b0;
    end else if (load) begin
      sinceLoad <= '0;
      capMin    <= (aIn == MINV) && (bIn == MINV);
      capZero   <= (aIn == '0) || (bIn == '0);
    end else if (sinceLoad != 8'hFF) begin
      sinceLoad <= sinceLoad + 8'd1;
    end
  end

  p_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    validOut && capZero |-> prodOut == '0);

  p_saturate_r3: assert property (@(posedge clk) disable iff (!rstN)
    validOut && capMin |-> prodOut == MAXV);

  p_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> sinceLoad == 8'(NDIG));

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut);

  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !load);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> $stable(prodOut));
endmodule

bind boothFracMul boothFracMul_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .aIn      (aIn),
  .bIn      (bIn),
  .prodOut  (prodOut),
  .validOut (validOut),
  .load     (ctl.load),
  .busy     (busy)
);

// File: tb/boothFracMul_test.sv
`timescale 1ns/1ps
module boothFracMul_test;
  localparam int N8 = 4;
  localparam int N5 = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0, startO = 1'b0;
  logic [7:0] aIn = '0, bIn = '0, prodOut;
  logic [4:0] aO = '0, bO = '0, prodO;
  logic       validOut, validO;
  int         compared = 0;
  int         mismatched = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  boothFracMul #(.W(8)) uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .aIn(aIn), .bIn(bIn),
    .prodOut(prodOut), .validOut(validOut));

  boothFracMul #(.W(5)) uutOdd (
    .clk(clk), .rstN(rstN), .startIn(startO), .aIn(aO), .bIn(bO),
    .prodOut(prodO), .validOut(validO));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect8(int a, int b);
    int q = (a * b) >>> 7;
    if (q > 127) q = 127;
    return q & 255;
  endfunction

  function automatic int expect5(int a, int b);
    int q = (a * b) >>> 4;
    if (q > 15) q = 15;
    return q & 31;
  endfunction

  // R2/R4: one operation on the W=8 instance, result due N8 edges after accept.
  task automatic run8(input int a, input int b, input string req);
    bit early = 1'b0;
    @(negedge clk);
    aIn = a[7:0]; bIn = b[7:0]; startIn = 1'b1;
    for (int k = 1; k <= N8 + 1; k++) begin
      @(negedge clk);
      startIn = 1'b0;
      if (k <= N8 && validOut) early = 1'b1;
    end
    check(validOut && !early, "R4 latency W=8", int'(validOut), 1);
    check(int'(prodOut) == expect8(a, b), req, int'(prodOut), expect8(a, b));
  endtask

  // R7: one operation on the W=5 instance.
  task automatic run5(input int a, input int b);
    bit early = 1'b0;
    @(negedge clk);
    aO = a[4:0]; bO = b[4:0]; startO = 1'b1;
    for (int k = 1; k <= N5 + 1; k++) begin
      @(negedge clk);
      startO = 1'b0;
      if (k <= N5 && validO) early = 1'b1;
    end
    check(validO && !early, "R7 latency W=5", int'(validO), 1);
    check(int'(prodO) == expect5(a, b), "R7 product W=5", int'(prodO), expect5(a, b));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(prodOut == 8'd0 && !validOut, "R1 reset W=8", int'(prodOut), 0);
    check(prodO == 5'd0 && !validO, "R1 reset W=5", int'(prodO), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(prodOut == 8'd0 && !validOut, "R1 after release", int'(validOut), 0);

    // R3: the unrepresentable corner
    run8(-128, -128, "R3 saturate W=8");
    run8(-128, 127, "R2 min*max");
    run8(127, 127, "R2 max*max");
    run8(-1, -1, "R2 tiny*tiny");
    run8(-1, 1, "R2 floor negative");

    // R2: every multiplicand against a spread of multipliers
    for (int ai = -128; ai < 128; ai++) begin
      for (int j = 0; j < 20; j++) begin
        int bv;
        case (j)
          0: bv = 0;    1: bv = 1;    2: bv = -1;   3: bv = 127;
          4: bv = -128; 5: bv = 64;   6: bv = -64;  7: bv = 85;
          default: bv = ((j * 53 + ai * 7) & 255) - 128;
        endcase
        run8(ai, bv, "R2 product W=8");
      end
    end

    // R7: odd word length, exhaustive (includes its own R3 corner)
    for (int ai = -16; ai < 16; ai++)
      for (int bi = -16; bi < 16; bi++)
        run5(ai, bi);

    // R5: a second start while busy, with new operands, is ignored
    @(negedge clk);
    aIn = 8'h40; bIn = 8'h40; startIn = 1'b1;
    for (int k = 1; k <= N8 + 1; k++) begin
      @(negedge clk);
      startIn = (k == 2);
      if (k == 2) begin aIn = 8'h7F; bIn = 8'h81; end
    end
    check(validOut && prodOut == 8'h20, "R5 first operands kept", int'(prodOut), 32);
    begin
      bit extra = 1'b0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (validOut) extra = 1'b1;
      end
      check(!extra, "R5 no extra result", int'(extra), 0);
    end

    // R6: operands wiggle without a start; result holds
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      aIn = 8'(k * 31); bIn = 8'(k * 77);
    end
    check(prodOut == 8'h20 && !validOut, "R6 hold", int'(prodOut), 32);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule